// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a register-mapped controller for the serial management link between a MAC and its PHY devices. Software programs a clock divider and a preamble-skip option, then writes a 32-bit frame word. That write starts a transfer on the MDC/MDIO pair. The block first sends 32 one bits, unless the skip option is set. It then shifts the frame word out, most significant bit first. For a read, it releases the data line from the turnaround field onward. It captures the PHY's answer back into the low half of the same word.

The frame word is rotated in place. When a frame ends, the register again shows what was written. For a read, the low 16 bits are replaced by the PHY data. A sticky completion flag drives the interrupt output and is cleared by writing a one to it. MDC toggles every 2×N system clocks, where N is the 6-bit divider setting. A setting of zero parks MDC low. MDIO changes on MDC falling edges, and the block samples returning data on MDC rising edges.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, mdc_o, mdio_oe_o and irq_o are 0, and the registers at addresses 0, 1 and 2 read as zero.
- R2: With a nonzero divider N in control bits 6:1, MDC has a period of 4×N system clock cycles.
- R3: With divider 0, MDC stays low and shows no rising edges.
- R4: Writing address 0 starts a frame. When control bit 7 is 0, 32 driven one bits precede the frame bits.
- R5: When control bit 7 is 1, the first driven bit is frame bit 31, and no preamble is sent.
- R6: Frame bits go out MSB first. MDIO changes only on MDC falling edges, so it is stable at every MDC rising edge.
- R7: A frame whose bits 29:28 are not 2'b10 drives all 32 bit slots with mdio_oe_o high.
- R8: A frame whose bits 29:28 equal 2'b10 (a read) drives only slots 1 to 14. It holds mdio_oe_o low for slots 15 to 32.
- R9: After a read frame, address 0 reads back the written bits 31:16. Bits 15:0 hold the PHY bits sampled on the MDC rising edges of slots 17 to 32, first sample in bit 15.
- R10: After a non-read frame, address 0 reads back exactly the written word.
- R11: irq_o and status bit 0 (address 2) are set when a frame ends. They stay set until a write to address 2 with bit 0 = 1; a write with bit 0 = 0 leaves them set.
- R12: Address 1 reads back bits 7:1 as written; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 frame, 1 control, 2 status |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the PHY |
| irq_o | output | 1 | Frame-complete interrupt |

## Verification
If the slot counter is off by one, the number of driven bits changes. The release point of a read also moves. The bench sees both at the first frame's completion interrupt, and the rotated word reads back shifted. If the rotation or capture position is wrong, the post-frame readback is corrupted at once. This holds even when the line bits look right. Divider faults show up as a wrong MDC period within the first few rising edges of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int DIV_W    = 6;
  localparam int PRE_LEN  = 32;
  localparam int DATA_W   = 16;

  localparam logic [ADDR_W-1:0] ADDR_FRAME = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_FRAME = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             mdc_q;
  logic             run;
  logic             wrap;

  assign run     = |div_i;
  assign half_m1 = {div_i, 1'b0} - CNT_W'(1);
  assign wrap    = run && (cnt_q >= half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // strobes mark the edge at which mdc toggles
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int PRE_W   = 32,
  parameter int DAT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_data_i,
  input  logic               dis_pre_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic               done_o
);
  localparam int MAXC   = (PRE_W > FRAME_W) ? PRE_W : FRAME_W;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int TA_IDX = FRAME_W - DAT_W - 2;  // slots before turnaround
  localparam int SMP_LO = FRAME_W - DAT_W + 1;  // first data slot number
  localparam int OP_HI  = FRAME_W - 3;

  seq_st_e            st_q;
  logic [CW-1:0]      cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic               rd_q;
  logic               out_q;
  logic               oe_q;
  logic               done_q;
  logic               load_rd;

  assign load_rd = (load_data_i[OP_HI -: 2] == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sr_q   <= '0;
      rd_q   <= 1'b0;
      out_q  <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i && st_q == ST_IDLE) begin
        sr_q  <= load_data_i;
        rd_q  <= load_rd;
        cnt_q <= '0;
        st_q  <= dis_pre_i ? ST_FRAME : ST_PRE;
      end else begin
        if (load_i) sr_q <= load_data_i;  // mid-frame write replaces contents
        if (fall_i) begin
          unique case (st_q)
            ST_PRE: begin
              out_q <= 1'b1;
              oe_q  <= 1'b1;
              if (cnt_q == CW'(PRE_W - 1)) begin
                cnt_q <= '0;
                st_q  <= ST_FRAME;
              end else begin
                cnt_q <= cnt_q + CW'(1);
              end
            end
            ST_FRAME: begin
              if (cnt_q == CW'(FRAME_W)) begin
                st_q   <= ST_IDLE;
                oe_q   <= 1'b0;
                out_q  <= 1'b1;
                done_q <= 1'b1;
                cnt_q  <= '0;
              end else begin
                out_q <= sr_q[FRAME_W-1];
                oe_q  <= !(rd_q && cnt_q >= CW'(TA_IDX));
                cnt_q <= cnt_q + CW'(1);
                if (!load_i) sr_q <= {sr_q[FRAME_W-2:0], sr_q[FRAME_W-1]};
              end
            end
            default: ;
          endcase
        end else if (rise_i && !load_i && st_q == ST_FRAME && rd_q &&
                     cnt_q >= CW'(SMP_LO)) begin
          sr_q[0] <= mdio_i;  // PHY bit lands where its slot rotated to
        end
      end
    end
  end

  assign frame_o   = sr_q;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;
  assign done_o    = done_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int AW    = 2,
  parameter int DW    = 32,
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    frame_i,
  input  logic             done_i,
  output logic [DW-1:0]    rdata_o,
  output logic [DIV_W-1:0] div_o,
  output logic             dis_pre_o,
  output logic             irq_o,
  output logic             frame_load_o
);
  localparam int PRE_BIT = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic             dis_pre_q;
  logic             irq_q;
  logic             wr_ctrl;
  logic             wr_stat;

  assign wr_ctrl      = we_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_stat      = we_i && (addr_i == AW'(ADDR_STAT));
  assign frame_load_o = we_i && (addr_i == AW'(ADDR_FRAME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      dis_pre_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        div_q     <= wdata_i[DIV_W:1];
        dis_pre_q <= wdata_i[PRE_BIT];
      end
      if (done_i)                     irq_q <= 1'b1;
      else if (wr_stat && wdata_i[0]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_FRAME)) begin
      rdata_o = frame_i;
    end else if (addr_i == AW'(ADDR_CTRL)) begin
      rdata_o[DIV_W:1]  = div_q;
      rdata_o[PRE_BIT]  = dis_pre_q;
    end else if (addr_i == AW'(ADDR_STAT)) begin
      rdata_o[0] = irq_q;
    end
  end

  assign div_o     = div_q;
  assign dis_pre_o = dis_pre_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int ADDR_WIDTH = ADDR_W,
  parameter int BUS_WIDTH  = BUS_W,
  parameter int DIV_WIDTH  = DIV_W,
  parameter int PRE_BITS   = PRE_LEN,
  parameter int DATA_BITS  = DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic [ADDR_WIDTH-1:0] bus_addr_i,
  input  logic [BUS_WIDTH-1:0]  bus_wdata_i,
  output logic [BUS_WIDTH-1:0]  bus_rdata_o,
  output logic                  mdc_o,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  input  logic                  mdio_i,
  output logic                  irq_o
);
  logic [DIV_WIDTH-1:0] ctrl_div;
  logic                 ctrl_dis_pre;
  logic                 frame_load;
  logic                 frame_done;
  logic                 mdc_rise;
  logic                 mdc_fall;
  logic [BUS_WIDTH-1:0] frame_word;

  mdio_regs #(
    .AW   (ADDR_WIDTH),
    .DW   (BUS_WIDTH),
    .DIV_W(DIV_WIDTH)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .frame_i     (frame_word),
    .done_i      (frame_done),
    .rdata_o     (bus_rdata_o),
    .div_o       (ctrl_div),
    .dis_pre_o   (ctrl_dis_pre),
    .irq_o       (irq_o),
    .frame_load_o(frame_load)
  );

  mdio_clk_div #(
    .DIV_W(DIV_WIDTH)
  ) u_clk_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (ctrl_div),
    .mdc_o (mdc_o),
    .rise_o(mdc_rise),
    .fall_o(mdc_fall)
  );

  mdio_seq #(
    .FRAME_W(BUS_WIDTH),
    .PRE_W  (PRE_BITS),
    .DAT_W  (DATA_BITS)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (frame_load),
    .load_data_i(bus_wdata_i),
    .dis_pre_i  (ctrl_dis_pre),
    .rise_i     (mdc_rise),
    .fall_i     (mdc_fall),
    .mdio_i     (mdio_i),
    .frame_o    (frame_word),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .done_o     (frame_done)
  );
endmodule

// File: rtl/mdio_frame_engine_chk.sv
module mdio_frame_engine_chk #(
  parameter int AW    = 2,
  parameter int DW    = 32,
  parameter int DIV_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [DW-1:0]    bus_wdata_i,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe_o,
  input logic             irq_o,
  input logic [DIV_W-1:0] div_q
);
  a_r3_mdc_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0) |=> !mdc_o);

  a_r6_mdio_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $stable(mdio_o));

  a_r6_oe_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> $fell(mdc_o));

  a_r11_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(bus_we_i && bus_addr_i == AW'(2) && bus_wdata_i[0])) |=> irq_o);

  a_r11_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && bus_we_i && bus_addr_i == AW'(2) && bus_wdata_i[0] && !$fell(mdc_o))
      |=> !irq_o);
endmodule

bind mdio_frame_engine mdio_frame_engine_chk #(
  .AW   (ADDR_WIDTH),
  .DW   (BUS_WIDTH),
  .DIV_W(DIV_WIDTH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o),
  .irq_o      (irq_o),
  .div_q      (ctrl_div)
);

// File: tb/mdio_frame_engine_bench.sv
module mdio_frame_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc_o, mdio_o, mdio_oe_o, irq_o;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_frame_engine u_mdio_frame_engine (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i), .irq_o(irq_o)
  );

  typedef struct {
    int          pre;
    logic [31:0] word;
    bit          rd;
  } exp_t;
  exp_t q[$];

  int n_vec = 0, n_bad = 0;
  int cyc = 0, last_rise = 0, rise_idx = 0, rises_total = 0;
  int drv_cnt = 0, rel_mon = 0, rel = 0, cur_div = 1;
  bit active = 0, started = 0;
  logic [127:0] cap = '0;
  logic [15:0]  phy_word = '0;
  logic prev_mdc = 1'b0, prev_irq = 1'b0;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor and PHY responder
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (irq_o && !prev_irq && active) begin
        exp_t e;
        logic [127:0] ev;
        int lo;
        e  = q.pop_front();
        ev = '0;
        lo = e.rd ? 18 : 0;
        for (int i = 0; i < e.pre; i++) ev = {ev[126:0], 1'b1};
        for (int b = 31; b >= lo; b--) ev = {ev[126:0], e.word[b]};
        check(e.pre != 0 ? "R4 driven count" : "R5 driven count", 128'(drv_cnt), 128'(e.pre + 32 - lo));
        check(e.rd ? "R8 released slots" : "R7 released slots", 128'(rel_mon), 128'(e.rd ? 18 : 0));
        check(e.pre != 0 ? "R4/R6 line bits" : "R5/R6 line bits", cap, ev);
        active = 0;
      end
      if (mdc_o && !prev_mdc) begin
        rises_total++;
        if (active && started) begin
          if (mdio_oe_o) begin
            cap = {cap[126:0], mdio_o};
            drv_cnt++;
          end else begin
            rel_mon++;
          end
          rise_idx++;
          if (rise_idx == 5) check("R2 mdc period", 128'(cyc - last_rise), 128'(4 * cur_div));
        end
        last_rise = cyc;
      end
      if (!mdc_o && prev_mdc && active) begin
        started = 1;
        if (!mdio_oe_o) begin
          rel++;
          mdio_i = (rel >= 3 && rel <= 18) ? phy_word[18-rel] : 1'b0;
        end else begin
          mdio_i = 1'b1;
        end
      end
    end
    prev_mdc = mdc_o;
    prev_irq = irq_o;
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run_frame(input logic [31:0] word, input bit dis_pre,
                           input logic [5:0] div, input logic [15:0] phy);
    logic [31:0] rb;
    bit rd;
    rd = (word[29:28] == 2'b10);
    bus_write(2'd1, {24'd0, dis_pre, div, 1'b0});
    cur_div  = div;
    phy_word = phy;
    q.push_back('{pre: dis_pre ? 0 : 32, word: word, rd: rd});
    cap = '0; drv_cnt = 0; rel_mon = 0; rel = 0; rise_idx = 0; started = 0;
    bus_write(2'd0, word);
    #1 active = 1;
    while (active) @(negedge clk);
    bus_read(2'd0, rb);
    if (rd) check("R9 read result", 128'(rb), 128'({word[31:16], phy}));
    else    check("R10 write readback", 128'(rb), 128'(word));
    bus_read(2'd2, rb);
    check("R11 status set", 128'(rb), 128'd1);
    bus_write(2'd2, 32'h0);
    bus_read(2'd2, rb);
    check("R11 zero write keeps flag", 128'(rb), 128'd1);
    bus_write(2'd2, 32'h1);
    bus_read(2'd2, rb);
    check("R11 w1c clears", 128'({irq_o, rb}), 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pins", 128'({mdc_o, mdio_oe_o, irq_o}), 128'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 3; a++) begin
      bus_read(2'(a), rb);
      check("R1 register reset", 128'(rb), 128'd0);
    end
    // R3 divider zero keeps mdc low
    r0 = rises_total;
    repeat (200) @(negedge clk);
    check("R3 no mdc edges", 128'({rises_total - r0, mdc_o}), 128'd0);
    // R12 control readback
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, rb);
    check("R12 control readback", 128'(rb), 128'h0000_00FE);
    bus_write(2'd1, 32'h0);
    repeat (10) @(negedge clk);
    r0 = rises_total;
    repeat (150) @(negedge clk);
    check("R3 stopped after reprogram", 128'({rises_total - r0, mdc_o}), 128'd0);

    // read, preamble, div 1
    run_frame({2'b01, 2'b10, 5'h05, 5'h02, 2'b10, 16'h5A5A}, 1'b0, 6'd1, 16'hBEEF);
    // write, preamble, div 2
    run_frame({2'b01, 2'b01, 5'h1F, 5'h11, 2'b10, 16'hC3A5}, 1'b0, 6'd2, 16'h0000);
    // read, no preamble, div 3
    run_frame({2'b01, 2'b10, 5'h0A, 5'h1E, 2'b10, 16'h0000}, 1'b1, 6'd3, 16'h8001);
    // write, no preamble, div 1
    run_frame({2'b01, 2'b01, 5'h00, 5'h00, 2'b10, 16'hA5A5}, 1'b1, 6'd1, 16'hFFFF);
    // read returning all ones
    run_frame({2'b01, 2'b10, 5'h13, 5'h07, 2'b10, 16'h1234}, 1'b0, 6'd2, 16'hFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule